// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit input address into a 32-bit output address by walking a two-level translation table held in memory. Each table entry is a 32-bit descriptor. A request carries the input address and the table base. The block reads one descriptor word at a time through a simple memory read port. A first-level entry may be a final mapping or a pointer to a second-level table; in the pointer case the block makes one more read.

The walk returns one of two outcomes. A successful walk gives the composed output address, the mapping size, the decoded permissions and the memory type. A failed walk gives a fault flag that also tells which level failed. The result stays on the outputs until the requester takes it.

Two mapping kinds repeat one descriptor over a block sixteen times larger: the 16 MB first-level mapping and the 64 KB second-level mapping. For these, four more low address bits pass through from the input.

Top module: `sd_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0. A new request is accepted only while no walk is in progress.
- R2: The first read goes to the address {base[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor whose bits [1:0] are 00 ends the walk with `res_fault`=1 and `res_fault_l2`=0. No second read is made.
- R4: A first-level descriptor with bit 1 set, or with bits [1:0]=11, is a 1 MB mapping when bit 18 is clear. For it, `res_pa`={d[31:20], va[19:0]}, `res_size`=2, `res_xn`=d[4], `res_ro`=d[15] and `res_unpriv`=d[11].
- R5: The same descriptor with bit 18 set is a 16 MB mapping. For it, `res_pa`={d[31:24], va[23:0]} and `res_size`=3.
- R6: A first-level descriptor with bits [1:0]=01 points to a second-level table. The second read goes to {d[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with bit 1 set is a 4 KB mapping. For it, `res_pa`={d[31:12], va[11:0]}, `res_size`=0, `res_xn`=d[0], `res_ro`=d[9] and `res_unpriv`=d[5].
- R8: A second-level descriptor with bits [1:0]=01 is a 64 KB mapping. For it, `res_pa`={d[31:16], va[15:0]}, `res_size`=1, `res_xn`=d[15], `res_ro`=d[9] and `res_unpriv`=d[5]. Its type field is taken from d[14:12].
- R9: A second-level descriptor with bits [1:0]=00 gives `res_fault`=1 and `res_fault_l2`=1.
- R10: The 3-bit type field is d[14:12] for both first-level mappings and for the 64 KB mapping, and d[8:6] for the 4 KB mapping. When it is zero, `res_device`=1 and `res_cache`=0. Otherwise `res_device`=0 and `res_cache`=d[3].
- R11: A memory request holds its valid and address until `mem_req_ready`, and at most one read is outstanding. A result holds `res_valid` and all result fields until `res_ready`.
- R12: On a fault, `res_pa`, `res_xn`, `res_ro`, `res_unpriv`, `res_device`, `res_cache` and `res_size` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and taking a request |
| req_va | input | 32 | Input address to translate |
| req_base | input | 32 | First-level table base |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_pa | output | 32 | Output address |
| res_fault | output | 1 | Translation fault |
| res_fault_l2 | output | 1 | Fault came from the second level |
| res_ro | output | 1 | Region is read-only |
| res_unpriv | output | 1 | Unprivileged access allowed |
| res_xn | output | 1 | Execute-never |
| res_device | output | 1 | Device memory type |
| res_cache | output | 1 | Cacheable memory |
| res_size | output | 2 | 0: 4 KB, 1: 64 KB, 2: 1 MB, 3: 16 MB |

## Verification
The bench builds the walker with the default repeat factor of 16 (`CONT_LOG2`=4). At that setting the 64 KB and 16 MB mappings pass exactly four more input bits than their base sizes, so a mask that is too narrow or too wide shows up in the output address. The memory model answers only at the two addresses each scenario expects, which makes any wrong index or base slice appear as a fault and an unexpected-read count. The 64 KB scenario puts a zero in the 4 KB type position and a non-zero value in the relocated one; the type field and execute-never bit are read from their own positions only in that case.

// File: rtl/sd_walker.sv
module sd_walker #(
  parameter int CONT_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [31:0] req_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_pa,
  output logic        res_fault,
  output logic        res_fault_l2,
  output logic        res_ro,
  output logic        res_unpriv,
  output logic        res_xn,
  output logic        res_device,
  output logic        res_cache,
  output logic [1:0]  res_size
);
  localparam logic [31:0] ONES     = '1;
  localparam logic [31:0] M_SMALL  = ONES << 12;
  localparam logic [31:0] M_LARGE  = ONES << (12 + CONT_LOG2);
  localparam logic [31:0] M_SECT   = ONES << 20;
  localparam logic [31:0] M_SUPER  = ONES << (20 + CONT_LOG2);

  typedef enum logic [2:0] {IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, DONE} st_t;

  st_t         st;
  logic [31:0] va_q, base_q, desc_q;
  logic        lvl2_q, flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      va_q   <= '0;
      base_q <= '0;
      desc_q <= '0;
      lvl2_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= req_base;
          st     <= L1_REQ;
        end
        L1_REQ: if (mem_req_ready) st <= L1_WAIT;
        L1_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          lvl2_q <= 1'b0;
          flt_q  <= (mem_rsp_data[1:0] == 2'b00);
          st     <= (mem_rsp_data[1:0] == 2'b01) ? L2_REQ : DONE;
        end
        L2_REQ: if (mem_req_ready) st <= L2_WAIT;
        L2_WAIT: if (mem_rsp_valid) begin
          desc_q <= mem_rsp_data;
          lvl2_q <= 1'b1;
          flt_q  <= (mem_rsp_data[1:0] == 2'b00);
          st     <= DONE;
        end
        DONE: if (res_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == L1_REQ) || (st == L2_REQ);
  assign mem_req_addr  = (st == L2_REQ) ? {desc_q[31:10], va_q[19:12], 2'b00}
                                        : {base_q[31:14], va_q[31:20], 2'b00};
  assign res_valid     = (st == DONE);

  logic        is_large, is_super, xn, ok;
  logic [7:0]  attr;
  logic [2:0]  tex;
  logic [31:0] mask;

  assign is_large = lvl2_q & ~desc_q[1];
  assign is_super = ~lvl2_q & desc_q[18];
  assign attr     = lvl2_q ? desc_q[11:4] : desc_q[17:10];
  assign tex      = is_large ? desc_q[14:12] : attr[4:2];
  assign xn       = lvl2_q ? (desc_q[1] ? desc_q[0] : desc_q[15]) : desc_q[4];
  assign mask     = lvl2_q ? (is_large ? M_LARGE : M_SMALL) : (is_super ? M_SUPER : M_SECT);
  assign ok       = ~flt_q;

  assign res_fault    = flt_q;
  assign res_fault_l2 = flt_q & lvl2_q;
  assign res_pa       = ok ? ((desc_q & mask) | (va_q & ~mask)) : '0;
  assign res_ro       = ok & attr[5];
  assign res_unpriv   = ok & attr[1];
  assign res_xn       = ok & xn;
  assign res_device   = ok & (tex == 3'b000);
  assign res_cache    = ok & (tex != 3'b000) & desc_q[3];
  assign res_size     = ok ? {~lvl2_q, lvl2_q ? is_large : is_super} : 2'b00;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_fault)
                                   && $stable(res_size) && $stable(res_xn)));

  a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_pa == 32'h0 && !res_xn && !res_ro && !res_unpriv
                                  && !res_device && !res_cache && res_size == 2'b00));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_pa[11:0] == va_q[11:0]));

  a_r10_type_excl: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_device && res_cache));
endmodule

// File: tb/tb_sd_walker.sv
`timescale 1ns/1ps
module tb_sd_walker;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_va = 0, req_base = 0;
  logic        mem_req_valid, mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        res_valid, res_ready = 0;
  logic [31:0] res_pa;
  logic        res_fault, res_fault_l2, res_ro, res_unpriv, res_xn, res_device, res_cache;
  logic [1:0]  res_size;

  sd_walker dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int reads = 0, stray = 0;
  logic [31:0] l1a, l1d, l2a, l2d;

  logic [31:0] g_pa;
  logic        g_f, g_f2, g_ro, g_up, g_xn, g_dev, g_c;
  logic [1:0]  g_sz;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : memmodel
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] a = 0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          pend = 0;
          mem_rsp_valid <= 1'b1;
          if (a == l1a) mem_rsp_data <= l1d;
          else if (a == l2a) mem_rsp_data <= l2d;
          else begin mem_rsp_data <= 32'h0; stray++; end
        end else cnt--;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; cnt = 1; a = mem_req_addr; reads++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic walk(logic [31:0] va, logic [31:0] base, bit hold, bit stall);
    int n = 0;
    reads = 0; stray = 0;
    @(negedge clk);
    if (stall) mem_req_ready = 0;
    req_valid = 1; req_va = va; req_base = base;
    @(negedge clk);
    req_valid = 0;
    if (stall) begin
      repeat (3) @(negedge clk);
      chk("R11 stalled request valid", 32'(mem_req_valid), 32'd1);
      chk("R11 stalled request address", mem_req_addr, l1a);
      chk("R11 nothing read while stalled", reads, 0);
      mem_req_ready = 1;
    end
    while (!res_valid && n < 200) begin @(negedge clk); n++; end
    g_pa = res_pa; g_f = res_fault; g_f2 = res_fault_l2; g_ro = res_ro; g_up = res_unpriv;
    g_xn = res_xn; g_dev = res_device; g_c = res_cache; g_sz = res_size;
    if (hold) begin
      repeat (3) @(negedge clk);
      chk("R11 result held valid", 32'(res_valid), 32'd1);
      chk("R11 result held address", res_pa, g_pa);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk("R1 idle again after accept", 32'(req_ready), 32'd1);
  endtask

  task automatic expect_ok(string req, logic [31:0] pa, logic [1:0] sz,
                           bit xn, bit ro, bit up, bit dev, bit c, int nrd);
    chk({req, " fault"}, 32'(g_f), 32'd0);
    chk({req, " pa"}, g_pa, pa);
    chk({req, " size"}, 32'(g_sz), 32'(sz));
    chk({req, " xn"}, 32'(g_xn), 32'(xn));
    chk({req, " ro"}, 32'(g_ro), 32'(ro));
    chk({req, " unpriv"}, 32'(g_up), 32'(up));
    chk({req, " R10 device"}, 32'(g_dev), 32'(dev));
    chk({req, " R10 cache"}, 32'(g_c), 32'(c));
    chk({req, " R2/R6 read count"}, reads, nrd);
    chk({req, " R2 R6 stray reads"}, stray, 0);
  endtask

  task automatic expect_fault(string req, bit l2, int nrd);
    chk({req, " fault"}, 32'(g_f), 32'd1);
    chk({req, " level"}, 32'(g_f2), 32'(l2));
    chk({req, " R12 pa zero"}, g_pa, 32'h0);
    chk({req, " R12 attrs zero"}, {25'h0, g_xn, g_ro, g_up, g_dev, g_c, g_sz}, 32'h0);
    chk({req, " read count"}, reads, nrd);
    chk({req, " stray reads"}, stray, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    chk("R1 reset res_valid", 32'(res_valid), 32'd0);
    chk("R1 reset mem_req_valid", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_section();
    l1a = 32'h1234_EAF0; l1d = 32'h4560_941A; l2a = 32'hFFFF_FFF0; l2d = 0;
    walk(32'hABC1_2345, 32'h1234_C000, 0, 0);
    expect_ok("R4 section", 32'h4561_2345, 2'd2, 1, 1, 0, 0, 1, 1);
  endtask

  task automatic t_super();
    l1a = 32'h0000_4048; l1d = 32'h7A04_0802; l2a = 32'hFFFF_FFF0; l2d = 0;
    walk(32'h0123_4567, 32'h0000_4000, 1, 0);
    expect_ok("R5 supersection", 32'h7A23_4567, 2'd3, 0, 0, 1, 1, 0, 1);
  endtask

  task automatic t_l1_fault();
    l1a = 32'h0000_2000; l1d = 32'hFFFF_FFFC; l2a = 32'hFFFF_FFF0; l2d = 0;
    walk(32'h8000_0042, 32'h0000_0000, 1, 0);
    expect_fault("R3 level-1 fault", 0, 1);
  endtask

  task automatic t_small();
    l1a = 32'h0010_0C00; l1d = 32'h0ABC_DC01; l2a = 32'h0ABC_DD58; l2d = 32'h9876_5073;
    walk(32'h3005_6789, 32'h0010_0000, 0, 1);
    expect_ok("R7 R6 small page", 32'h9876_5789, 2'd0, 1, 0, 1, 0, 0, 2);
  endtask

  task automatic t_large();
    l1a = 32'h0000_03C0; l1d = 32'h0000_1001; l2a = 32'h0000_12AC; l2d = 32'h5555_A209;
    walk(32'h0F0A_BCDE, 32'h0000_0000, 0, 0);
    expect_ok("R8 large page", 32'h5555_BCDE, 2'd1, 1, 1, 0, 0, 1, 2);
  endtask

  task automatic t_l2_fault();
    l1a = 32'h0000_0000; l1d = 32'h0000_2001; l2a = 32'h0000_2004; l2d = 32'h000F_FF0C;
    walk(32'h0000_1000, 32'h0000_0000, 0, 0);
    expect_fault("R9 level-2 fault", 1, 2);
  endtask

  task automatic t_type11();
    l1a = 32'h0000_8000; l1d = 32'h1230_0003; l2a = 32'hFFFF_FFF0; l2d = 0;
    walk(32'h0000_0ABC, 32'h0000_8000, 0, 0);
    expect_ok("R4 type-11 section", 32'h1230_0ABC, 2'd2, 0, 0, 0, 1, 0, 1);
  endtask

  initial begin
    l1a = 32'hFFFF_FFF0; l1d = 0; l2a = 32'hFFFF_FFF0; l2d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_section();
    t_super();
    t_l1_fault();
    t_small();
    t_large();
    t_l2_fault();
    t_type11();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule